// File: doc/BRIEF.md
# Timeslot Switch with Loopback

The block is a time-division switch sitting between a line-side serial frame interface and a trunk-side serial frame interface. Each frame carries `SLOTS` timeslots of `BYTE_W` bits. Bit serialisation is done elsewhere, so every timeslot arrives as one strobe that carries the received line byte and the received trunk byte together. A frame-sync input marks timeslot 0. Bytes received on the line side go upstream. They are scattered into an upstream data memory at a trunk timeslot chosen per line slot. Bytes received on the trunk side go downstream and are stored in a downstream data memory at their own slot.

Each line output timeslot has its own control entry, and that entry gathers its byte from either data memory. A direction bit in the entry picks the memory. Because of this, a line byte parked in a spare trunk slot can be read straight back out on another line slot. That closes a loop with no external wiring. A per-slot tristate bit decides whether the trunk output actually drives the looped byte (transparent) or stays undriven (non-transparent).

Both data memories are double buffered by frame, so every switched byte leaves one frame after it arrived. Control writes from the host port are staged and copied into the working set at the next frame sync, so every frame runs on one consistent routing.

Top module: `tss_switch`

## Requirements
- R1: After reset, `line_tx` and `trunk_tx` are 0xFF and `trunk_oe` and `out_vld` are 0. Every control entry is unconnected and every tristate bit is set to high impedance.
- R2: `out_vld` pulses exactly one cycle after each `slot_stb`, and outputs do not change in a cycle after no strobe. `out_slot` is 0 after a strobe that had `frame_sync` high, and otherwise it is one more than the previous slot, wrapping at `SLOTS`.
- R3: The source code layout is: bit `SW+1` = connect, bit `SW` = direction (1 = upstream data memory, 0 = downstream data memory), bits `SW-1:0` = slot. Here `SW` = clog2(`SLOTS`), which is 5 by default. A line output slot whose downstream entry has connect = 0 outputs 0xFF.
- R4: A downstream entry {connect 1, direction 0, slot k} makes its line output slot carry the trunk byte received in trunk slot k during the previous frame.
- R5: An upstream entry {connect 1, direction 1, slot k} at line slot i writes the line byte of slot i into upstream location k. Trunk output slot k carries that byte in the next frame. A trunk slot that no entry wrote in the previous frame outputs 0xFF.
- R6: An upstream entry with direction 0 or with connect 0 writes nothing into the upstream data memory.
- R7: A downstream entry {connect 1, direction 1, slot k} makes its line output slot carry upstream location k from the previous frame. A line-to-line loop is therefore set up by writing the same code value to the upstream entry of the source slot and to the downstream entry of the destination slot.
- R8: `trunk_oe` for a trunk output slot is the inverse of its tristate bit (1 = high impedance). `trunk_tx` carries the switched byte in both settings.
- R9: Host writes go to a staged copy and reach the working set at the next `frame_sync` strobe. A write made in the same cycle as that strobe waits for the following frame sync. `host_sel` codes are 0 = upstream entries, 1 = downstream entries, 2 = tristate bits (`host_code[0]`), and 3 is ignored.
- R10: A byte received in frame N appears on an output in frame N+1 and never in frame N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync | input | 1 | Qualifies a strobe as timeslot 0 of a new frame |
| slot_stb | input | 1 | One pulse per timeslot |
| line_rx | input | BYTE_W | Line-side received byte (upstream) |
| trunk_rx | input | BYTE_W | Trunk-side received byte (downstream) |
| host_we | input | 1 | Host write enable |
| host_sel | input | 2 | Host write target |
| host_addr | input | SW | Entry index (timeslot) |
| host_code | input | SW+2 | Source code, or tristate value in bit 0 |
| line_tx | output | BYTE_W | Line-side output byte (downstream) |
| trunk_tx | output | BYTE_W | Trunk-side output byte (upstream) |
| trunk_oe | output | 1 | Trunk output enable for the current slot |
| out_vld | output | 1 | Outputs carry a new timeslot |
| out_slot | output | SW | Timeslot index of the current outputs |

## Verification
A corrupted routing entry shows up on the affected output slot within one frame as a wrong byte or as a stray 0xFF. A bank pointer that toggles at the wrong time shows bytes from the current frame, or from two frames back, on the very next frame sync. A staged entry that leaks early into the working set changes an output in the frame where the write was made, so the bench compares every output slot of every frame against its own frame-by-frame model. An unreached upstream slot or a misdecoded host target turns into a mismatch on the slot it touched by the following frame.

// File: rtl/tss_pkg.sv
package tss_pkg;
   typedef enum logic [1:0] {
      TGT_UP_CM = 2'd0,
      TGT_DN_CM = 2'd1,
      TGT_TRI   = 2'd2,
      TGT_NONE  = 2'd3
   } tss_tgt_e;
endpackage

// File: rtl/tss_slot_timer.sv
// Timeslot counter and frame bank pointer. All outputs are valid in the strobe cycle.
module tss_slot_timer #(
   parameter int SLOTS = 32,
   localparam int SW = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_sync,
   input  logic          slot_stb,
   output logic [SW-1:0] cur_slot,
   output logic          wr_bank,
   output logic          commit
);
   localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

   logic [SW-1:0] slot_q;
   logic          bank_q;

   assign commit   = slot_stb & frame_sync;
   assign cur_slot = frame_sync ? '0 : ((slot_q == LAST) ? '0 : slot_q + 1'b1);
   assign wr_bank  = commit ? ~bank_q : bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= LAST;
         bank_q <= 1'b0;
      end else if (slot_stb) begin
         slot_q <= cur_slot;
         bank_q <= wr_bank;
      end
   end
endmodule

// File: rtl/tss_ctrl_mem.sv
// Staged/working control store: host writes land in the staged copy, commit copies all.
module tss_ctrl_mem #(
   parameter int DEPTH = 32,
   parameter int W = 7,
   parameter logic [W-1:0] RST_VAL = '0,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          commit,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] staged [DEPTH];
   logic [W-1:0] working [DEPTH];

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("tss_ctrl_mem: DEPTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            staged[i]  <= RST_VAL;
            working[i] <= RST_VAL;
         end
      end else begin
         if (commit) begin
            for (int i = 0; i < DEPTH; i++) working[i] <= staged[i];
         end
         if (we) staged[waddr] <= wdata;
      end
   end

   // At the commit strobe the new routing already applies to slot 0.
   assign rdata = commit ? staged[raddr] : working[raddr];
endmodule

// File: rtl/tss_data_mem.sv
// Two-bank frame buffer: one bank written this frame, the other read.
module tss_data_mem #(
   parameter int DEPTH = 32,
   parameter int W = 8,
   parameter int RD_PORTS = 1,
   parameter bit CLEAR_ON_SWAP = 1'b0,
   parameter logic [W-1:0] IDLE = '1,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_bank,
   input  logic                         swap,
   input  logic                         wr_en,
   input  logic [AW-1:0]                wr_addr,
   input  logic [W-1:0]                 wr_data,
   input  logic [RD_PORTS-1:0][AW-1:0]  rd_addr,
   output logic [RD_PORTS-1:0][W-1:0]   rd_data
);
   logic [W-1:0] mem [2][DEPTH];
   logic         rd_bank;

   generate
      if (RD_PORTS < 1) begin : g_bad_ports
         $error("tss_data_mem: RD_PORTS must be at least 1");
      end
   endgenerate

   assign rd_bank = ~wr_bank;

   generate
      if (CLEAR_ON_SWAP) begin : g_clear
         // Scatter-written store: stale locations are flushed to IDLE each frame.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int b = 0; b < 2; b++)
                  for (int i = 0; i < DEPTH; i++) mem[b][i] <= IDLE;
            end else begin
               if (swap) begin
                  for (int i = 0; i < DEPTH; i++) mem[wr_bank][i] <= IDLE;
               end
               if (wr_en) mem[wr_bank][wr_addr] <= wr_data;
            end
         end
      end else begin : g_keep
         // Every location is rewritten each frame: no flush needed.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int b = 0; b < 2; b++)
                  for (int i = 0; i < DEPTH; i++) mem[b][i] <= IDLE;
            end else if (wr_en) begin
               mem[wr_bank][wr_addr] <= wr_data;
            end
         end
      end
   endgenerate

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assign rd_data[p] = mem[rd_bank][rd_addr[p]];
   end
endmodule

// File: rtl/tss_switch.sv
module tss_switch
   import tss_pkg::*;
#(
   parameter int SLOTS = 32,
   parameter int BYTE_W = 8,
   localparam int SW = $clog2(SLOTS),
   localparam int CW = SW + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_sync,
   input  logic              slot_stb,
   input  logic [BYTE_W-1:0] line_rx,
   input  logic [BYTE_W-1:0] trunk_rx,
   input  logic              host_we,
   input  logic [1:0]        host_sel,
   input  logic [SW-1:0]     host_addr,
   input  logic [CW-1:0]     host_code,
   output logic [BYTE_W-1:0] line_tx,
   output logic [BYTE_W-1:0] trunk_tx,
   output logic              trunk_oe,
   output logic              out_vld,
   output logic [SW-1:0]     out_slot
);
   localparam int BIT_CONN = CW - 1;
   localparam int BIT_DIR  = SW;
   localparam logic [BYTE_W-1:0] IDLE_BYTE = '1;

   generate
      if (SLOTS < 2) begin : g_bad_slots
         $error("tss_switch: SLOTS must be at least 2");
      end
      if (BYTE_W < 1) begin : g_bad_width
         $error("tss_switch: BYTE_W must be at least 1");
      end
   endgenerate

   // Frame timing
   logic [SW-1:0] cur_slot;
   logic          wr_bank;
   logic          commit;

   tss_slot_timer #(.SLOTS(SLOTS)) i_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_sync (frame_sync),
      .slot_stb   (slot_stb),
      .cur_slot   (cur_slot),
      .wr_bank    (wr_bank),
      .commit     (commit)
   );

   // Host decode
   tss_tgt_e sel;
   assign sel = tss_tgt_e'(host_sel);

   logic we_up, we_dn, we_tri;
   assign we_up  = host_we && (sel == TGT_UP_CM);
   assign we_dn  = host_we && (sel == TGT_DN_CM);
   assign we_tri = host_we && (sel == TGT_TRI);

   // Control stores, all indexed by the current timeslot
   logic [CW-1:0] up_code;
   logic [CW-1:0] dn_code;
   logic          tri_hiz;

   tss_ctrl_mem #(.DEPTH(SLOTS), .W(CW), .RST_VAL('0)) i_up_cm (
      .clk (clk), .rst_n (rst_n),
      .we (we_up), .waddr (host_addr), .wdata (host_code),
      .commit (commit), .raddr (cur_slot), .rdata (up_code)
   );

   tss_ctrl_mem #(.DEPTH(SLOTS), .W(CW), .RST_VAL('0)) i_dn_cm (
      .clk (clk), .rst_n (rst_n),
      .we (we_dn), .waddr (host_addr), .wdata (host_code),
      .commit (commit), .raddr (cur_slot), .rdata (dn_code)
   );

   tss_ctrl_mem #(.DEPTH(SLOTS), .W(1), .RST_VAL(1'b1)) i_tri (
      .clk (clk), .rst_n (rst_n),
      .we (we_tri), .waddr (host_addr), .wdata (host_code[0]),
      .commit (commit), .raddr (cur_slot), .rdata (tri_hiz)
   );

   // Upstream data memory: scattered by line slot, read by trunk slot and by loops
   logic                     up_wr;
   logic [1:0][SW-1:0]       up_raddr;
   logic [1:0][BYTE_W-1:0]   up_rdata;

   assign up_wr       = slot_stb & up_code[BIT_CONN] & up_code[BIT_DIR];
   assign up_raddr[0] = cur_slot;
   assign up_raddr[1] = dn_code[SW-1:0];

   tss_data_mem #(
      .DEPTH(SLOTS), .W(BYTE_W), .RD_PORTS(2), .CLEAR_ON_SWAP(1'b1), .IDLE(IDLE_BYTE)
   ) i_up_dm (
      .clk (clk), .rst_n (rst_n),
      .wr_bank (wr_bank), .swap (commit),
      .wr_en (up_wr), .wr_addr (up_code[SW-1:0]), .wr_data (line_rx),
      .rd_addr (up_raddr), .rd_data (up_rdata)
   );

   // Downstream data memory: written in trunk slot order
   logic [0:0][SW-1:0]     dn_raddr;
   logic [0:0][BYTE_W-1:0] dn_rdata;

   assign dn_raddr[0] = dn_code[SW-1:0];

   tss_data_mem #(
      .DEPTH(SLOTS), .W(BYTE_W), .RD_PORTS(1), .CLEAR_ON_SWAP(1'b0), .IDLE(IDLE_BYTE)
   ) i_dn_dm (
      .clk (clk), .rst_n (rst_n),
      .wr_bank (wr_bank), .swap (commit),
      .wr_en (slot_stb), .wr_addr (cur_slot), .wr_data (trunk_rx),
      .rd_addr (dn_raddr), .rd_data (dn_rdata)
   );

   // Output selection
   logic [BYTE_W-1:0] line_sel;

   always_comb begin
      if (!dn_code[BIT_CONN])     line_sel = IDLE_BYTE;
      else if (dn_code[BIT_DIR])  line_sel = up_rdata[1];
      else                        line_sel = dn_rdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_tx  <= IDLE_BYTE;
         trunk_tx <= IDLE_BYTE;
         trunk_oe <= 1'b0;
         out_vld  <= 1'b0;
         out_slot <= '0;
      end else begin
         out_vld <= slot_stb;
         if (slot_stb) begin
            line_tx  <= line_sel;
            trunk_tx <= up_rdata[0];
            trunk_oe <= ~tri_hiz;
            out_slot <= cur_slot;
         end
      end
   end
endmodule

// File: rtl/tss_switch_chk.sv
module tss_switch_chk #(
   parameter int SLOTS = 32,
   parameter int BYTE_W = 8,
   localparam int SW = $clog2(SLOTS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_sync,
   input logic              slot_stb,
   input logic [BYTE_W-1:0] line_tx,
   input logic [BYTE_W-1:0] trunk_tx,
   input logic              trunk_oe,
   input logic              out_vld,
   input logic [SW-1:0]     out_slot
);
   logic seen_commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       seen_commit <= 1'b0;
      else if (slot_stb && frame_sync)  seen_commit <= 1'b1;
   end

   AST_VLD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
      slot_stb |=> out_vld); // R2

   AST_NO_VLD_WITHOUT_STB: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_stb |=> !out_vld); // R2

   AST_SYNC_GIVES_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_stb && frame_sync) |=> (out_slot == '0)); // R2

   AST_OUTPUTS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_stb |=> ($stable(line_tx) && $stable(trunk_tx) && $stable(trunk_oe))); // R2

   AST_OE_OFF_BEFORE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_commit |-> !trunk_oe); // R1
endmodule

bind tss_switch tss_switch_chk #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_sync (frame_sync),
   .slot_stb   (slot_stb),
   .line_tx    (line_tx),
   .trunk_tx   (trunk_tx),
   .trunk_oe   (trunk_oe),
   .out_vld    (out_vld),
   .out_slot   (out_slot)
);

// File: tb/test_tss_switch.sv
module test_tss_switch;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int N = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_sync = 1'b0;
   logic       slot_stb = 1'b0;
   logic [7:0] line_rx = '0;
   logic [7:0] trunk_rx = '0;
   logic       host_we = 1'b0;
   logic [1:0] host_sel = '0;
   logic [4:0] host_addr = '0;
   logic [6:0] host_code = '0;
   logic [7:0] line_tx;
   logic [7:0] trunk_tx;
   logic       trunk_oe;
   logic       out_vld;
   logic [4:0] out_slot;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   tss_switch i_tss_switch (
      .clk (clk), .rst_n (rst_n), .frame_sync (frame_sync), .slot_stb (slot_stb),
      .line_rx (line_rx), .trunk_rx (trunk_rx),
      .host_we (host_we), .host_sel (host_sel), .host_addr (host_addr), .host_code (host_code),
      .line_tx (line_tx), .trunk_tx (trunk_tx), .trunk_oe (trunk_oe),
      .out_vld (out_vld), .out_slot (out_slot)
   );

   // Reference state built from the requirements
   logic [6:0] up_stg [N], up_wrk [N], dn_stg [N], dn_wrk [N];
   logic       hz_stg [N], hz_wrk [N];
   logic [7:0] up_cur [N], up_prev [N], dn_cur [N], dn_prev [N];
   int         m_slot = N - 1;

   typedef struct {
      int         slot;
      logic [7:0] lb;
      logic [7:0] tb;
      logic       oe;
      string      lt;
      string      tt;
   } exp_t;
   exp_t q [$];

   function automatic logic [6:0] code(input bit conn, input bit dir, input int sl);
      return {conn, dir, 5'(sl)};
   endfunction

   function automatic string line_tag(input int s);
      if (s == 3)  return "R4";
      if (s == 12) return "R7";
      if (s == 14) return "R9";
      return "R3";
   endfunction

   function automatic string trunk_tag(input int s);
      if (s == 7)  return "R10";
      if (s == 9)  return "R6";
      if (s == 20) return "R7";
      return "R5";
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic stage(input logic [1:0] sel, input int a, input logic [6:0] c);
      if (sel == 2'd0) up_stg[a] = c;
      else if (sel == 2'd1) dn_stg[a] = c;
      else if (sel == 2'd2) hz_stg[a] = c[0];
   endtask

   // One timeslot: strobe cycle followed by one idle cycle
   task automatic do_slot(input bit fs, input logic [7:0] lrx, input logic [7:0] trx,
                          input bit hw, input logic [1:0] hs, input int ha,
                          input logic [6:0] hc);
      exp_t e;
      int s;
      logic [6:0] c;
      @(negedge clk);
      frame_sync = fs; slot_stb = 1'b1; line_rx = lrx; trunk_rx = trx;
      host_we = hw; host_sel = hs; host_addr = 5'(ha); host_code = hc;
      if (fs) begin
         for (int i = 0; i < N; i++) begin
            up_wrk[i] = up_stg[i]; dn_wrk[i] = dn_stg[i]; hz_wrk[i] = hz_stg[i];
            up_prev[i] = up_cur[i]; dn_prev[i] = dn_cur[i]; up_cur[i] = 8'hFF;
         end
      end
      s = fs ? 0 : ((m_slot == N - 1) ? 0 : m_slot + 1);
      c = dn_wrk[s];
      e.slot = s;
      if (!c[6])     e.lb = 8'hFF;
      else if (c[5]) e.lb = up_prev[c[4:0]];
      else           e.lb = dn_prev[c[4:0]];
      e.tb = up_prev[s];
      e.oe = !hz_wrk[s];
      e.lt = line_tag(s);
      e.tt = trunk_tag(s);
      q.push_back(e);
      dn_cur[s] = trx;
      if (up_wrk[s][6] && up_wrk[s][5]) up_cur[up_wrk[s][4:0]] = lrx;
      if (hw) stage(hs, ha, hc);
      m_slot = s;
      @(negedge clk);
      slot_stb = 1'b0; frame_sync = 1'b0; host_we = 1'b0;
   endtask

   task automatic host_wr(input logic [1:0] sel, input int a, input logic [6:0] c);
      @(negedge clk);
      host_we = 1'b1; host_sel = sel; host_addr = 5'(a); host_code = c;
      stage(sel, a, c);
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic run_frame(input int f, input bit hw, input logic [1:0] hs,
                            input int ha, input logic [6:0] hc);
      for (int s = 0; s < N; s++) begin
         do_slot(s == 0, 8'((f * 37 + s * 5 + 3) & 8'h7F), 8'(8'h80 | ((f * 11 + s * 3) & 8'h7F)),
                 hw && (s == 0), hs, ha, hc);
      end
   endtask

   // Monitor: strobe-to-valid timing and scoreboard comparison
   logic stb_seen = 1'b0;
   always @(posedge clk) stb_seen <= slot_stb;

   always @(negedge clk) begin
      if (rst_n) begin
         check(out_vld == stb_seen, "R2", "out_vld vs strobe", out_vld, stb_seen);
         if (out_vld) begin
            if (q.size() == 0) begin
               check(1'b0, "R2", "unexpected output", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(out_slot == 5'(e.slot), "R2", "out_slot", out_slot, e.slot);
               check(line_tx == e.lb, e.lt, $sformatf("line_tx slot %0d", e.slot), line_tx, e.lb);
               check(trunk_tx == e.tb, e.tt, $sformatf("trunk_tx slot %0d", e.slot), trunk_tx, e.tb);
               check(trunk_oe == e.oe, "R8", $sformatf("trunk_oe slot %0d", e.slot), trunk_oe, e.oe);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         up_stg[i] = '0; up_wrk[i] = '0; dn_stg[i] = '0; dn_wrk[i] = '0;
         hz_stg[i] = 1'b1; hz_wrk[i] = 1'b1;
         up_cur[i] = 8'hFF; up_prev[i] = 8'hFF; dn_cur[i] = 8'hFF; dn_prev[i] = 8'hFF;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(line_tx == 8'hFF, "R1", "reset line_tx", line_tx, 8'hFF);
      check(trunk_tx == 8'hFF, "R1", "reset trunk_tx", trunk_tx, 8'hFF);
      check(trunk_oe == 1'b0, "R1", "reset trunk_oe", trunk_oe, 0);
      check(out_vld == 1'b0, "R1", "reset out_vld", out_vld, 0);

      // Unprogrammed frame: everything idle (R1, R3)
      run_frame(0, 1'b0, 2'd0, 0, '0);

      // Routing set up between frames; active from the next frame sync (R9)
      host_wr(2'd1, 3, code(1, 0, 5));     // R4 trunk slot 5 -> line slot 3
      host_wr(2'd0, 2, code(1, 1, 7));     // R5 line slot 2 -> trunk slot 7
      host_wr(2'd2, 7, 7'd0);              // R8 trunk slot 7 driven
      host_wr(2'd0, 4, code(1, 0, 9));     // R6 direction 0: no upstream write
      host_wr(2'd0, 10, code(1, 1, 20));   // R7 loop leg one via trunk slot 20
      host_wr(2'd1, 12, code(1, 1, 20));   // R7 loop leg two, same code value
      host_wr(2'd3, 14, code(1, 0, 1));    // R9 target 3 ignored

      run_frame(1, 1'b0, 2'd0, 0, '0);     // loop non-transparent: slot 20 undriven (R8)
      run_frame(2, 1'b0, 2'd0, 0, '0);
      run_frame(3, 1'b0, 2'd0, 0, '0);
      // R9: write in the frame-sync cycle waits one more frame
      run_frame(4, 1'b1, 2'd1, 14, code(1, 0, 5));
      host_wr(2'd2, 20, 7'd0);             // R8 transparent loop from frame 5
      run_frame(5, 1'b0, 2'd0, 0, '0);
      run_frame(6, 1'b0, 2'd0, 0, '0);

      repeat (4) @(negedge clk);
      check(q.size() == 0, "R2", "outputs outstanding", q.size(), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule